// File: doc/BRIEF.md
# Self-Refresh Exit Sequencer

This block sits in a synchronous DRAM controller and brings the memory back out of self refresh. While the memory is in self refresh it holds the clock-enable pin low and drives only no-operation commands. The device ignores every other pin during that time, including its clock. When an exit is requested, the block first waits until the system reports that the memory clock is running. It then raises clock enable and keeps the command bus at no-operation for a programmable row-cycle time (tRC). After that it can optionally issue a long burst of auto-refresh commands, with a full tRC of no-operation after each one.

Once the last window has elapsed, the sequencer raises a ready flag. The flag tells the scheduler that the memory is idle and may take normal traffic. The flag stays up until the scheduler asks to put the memory back into self refresh. That request drops clock enable and returns the sequencer to its holding state. Entering self refresh is handled elsewhere, and so are read and write scheduling.

Top module: `sr_exit_seq`

## Requirements
- R1: On synchronous reset, cke_o is 0, cmd_o is no-operation (2'b00) and ready_o is 0, with the sequencer in its holding state.
- R2: In the holding state, cke_o stays 0 and cmd_o stays 2'b00 for any values of enter_req, clk_running, burst_en and trc_cycles, as long as no exit_req has been seen.
- R3: An exit_req pulse seen in the holding state is remembered while clk_running is 0. cke_o rises in the cycle after the first clock edge at which the request is pending (or present) and clk_running is 1.
- R4: After cke_o rises, cmd_o is no-operation for exactly max(trc_cycles,1) cycles before the first auto refresh or before ready_o rises.
- R5: If burst_en is 1 at the start edge, exactly REF_COUNT (default 2048) auto-refresh commands (cmd_o = 2'b01) are issued. Each lasts one cycle and is followed by max(trc_cycles,1) no-operation cycles.
- R6: If burst_en is 0 at the start edge, no auto-refresh command is issued during the exit.
- R7: ready_o rises with cmd_o at no-operation and cke_o at 1. It then stays 1 until enter_req, and exit_req has no effect while ready.
- R8: enter_req while ready makes cke_o and ready_o 0 in the next cycle. The sequencer then waits for a fresh exit_req.
- R9: enter_req and exit_req during the exit sequence (between cke_o rising and ready_o rising) have no effect on cke_o, cmd_o or ready_o.
- R10: A trc_cycles value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| exit_req | input | 1 | Request to leave self refresh |
| enter_req | input | 1 | Request to return to self refresh (acted on only while ready) |
| clk_running | input | 1 | Memory clock is reported running |
| burst_en | input | 1 | Perform the auto-refresh burst on exit |
| trc_cycles | input | TRC_W | Row-cycle time in controller cycles |
| cke_o | output | 1 | Clock-enable drive to the memory |
| cmd_o | output | 2 | Command: 2'b00 no-operation, 2'b01 auto refresh |
| ready_o | output | 1 | Memory idle and open for normal operation |

## Verification
The assertions assume that trc_cycles and burst_en hold steady for the whole of an exit sequence, and that clk_running is a clean level. The stimulus changes those inputs only while the sequencer is in its holding state or when it is ready. It toggles enter_req and exit_req freely at any point, including in the middle of the exit sequence. Random tRC values include 0. The auto-refresh burst is enabled on only a few trials so that each full-length burst fits the run.

// File: rtl/sr_exit_pkg.sv
package sr_exit_pkg;
  typedef enum logic [1:0] {
    ST_HOLD    = 2'd0,
    ST_RECOVER = 2'd1,
    ST_REFRESH = 2'd2,
    ST_READY   = 2'd3
  } seq_state_t;

  localparam logic [1:0] CMD_NOP  = 2'b00;
  localparam logic [1:0] CMD_AREF = 2'b01;
endpackage

// File: rtl/sr_exit_timer.sv
// Down counter for the row-cycle window; expired when one cycle remains.
module sr_exit_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt > 1)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt <= W'(1));
endmodule

// File: rtl/sr_exit_refcnt.sv
// Counts auto-refresh commands still owed in the exit burst.
module sr_exit_refcnt #(
  parameter int REF_COUNT = 2048
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic burst,
  input  logic dec,
  output logic owed
);
  localparam int CW = $clog2(REF_COUNT + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)                   left <= '0;
    else if (load)             left <= burst ? CW'(REF_COUNT) : '0;
    else if (dec && left != 0) left <= left - 1'b1;
  end

  assign owed = (left != '0);
endmodule

// File: rtl/sr_exit_pend.sv
// Remembers an exit request taken in the holding state until it can start.
module sr_exit_pend (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic req,
  input  logic clr,
  output logic want
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst || clr)      pend <= 1'b0;
    else if (arm && req) pend <= 1'b1;
  end

  assign want = arm && (pend || req);
endmodule

// File: rtl/sr_exit_seq.sv
module sr_exit_seq #(
  parameter int TRC_W     = 8,
  parameter int REF_COUNT = 2048
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exit_req,
  input  logic             enter_req,
  input  logic             clk_running,
  input  logic             burst_en,
  input  logic [TRC_W-1:0] trc_cycles,
  output logic             cke_o,
  output logic [1:0]       cmd_o,
  output logic             ready_o
);
  import sr_exit_pkg::*;

  seq_state_t state;
  logic in_hold, want, start, expired, owed, tmr_load, ref_dec;

  assign in_hold  = (state == ST_HOLD);
  assign start    = want && clk_running;
  assign tmr_load = start || (state == ST_REFRESH);
  assign ref_dec  = (state == ST_RECOVER) && expired && owed;

  sr_exit_pend u_pend (
    .clk(clk), .rst(rst), .arm(in_hold), .req(exit_req), .clr(start), .want(want)
  );

  sr_exit_timer #(.W(TRC_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(trc_cycles), .expired(expired)
  );

  sr_exit_refcnt #(.REF_COUNT(REF_COUNT)) u_refs (
    .clk(clk), .rst(rst), .load(start), .burst(burst_en), .dec(ref_dec), .owed(owed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HOLD;
      cke_o   <= 1'b0;
      cmd_o   <= CMD_NOP;
      ready_o <= 1'b0;
    end else begin
      case (state)
        ST_HOLD: begin
          cmd_o <= CMD_NOP;
          if (start) begin
            state <= ST_RECOVER;
            cke_o <= 1'b1;
          end
        end
        ST_RECOVER: begin
          if (expired) begin
            if (owed) begin
              state <= ST_REFRESH;
              cmd_o <= CMD_AREF;
            end else begin
              state   <= ST_READY;
              ready_o <= 1'b1;
            end
          end
        end
        ST_REFRESH: begin
          state <= ST_RECOVER;
          cmd_o <= CMD_NOP;
        end
        default: begin
          if (enter_req) begin
            state   <= ST_HOLD;
            cke_o   <= 1'b0;
            ready_o <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/sr_exit_seq_chk.sv
module sr_exit_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       clk_running,
  input logic       enter_req,
  input logic       cke_o,
  input logic [1:0] cmd_o,
  input logic       ready_o
);
  // R2
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cke_o |-> cmd_o == 2'b00);

  // R3
  clock_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_o) |-> $past(clk_running));

  // R4
  first_nop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_o) |-> (cmd_o == 2'b00 && !ready_o));

  // R5
  aref_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_o == 2'b01 |=> cmd_o == 2'b00);

  // R5
  aref_after_nop_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_o == 2'b01 |-> ($past(cmd_o) == 2'b00 && $past(cke_o)));

  // R7
  ready_clean_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (cke_o && cmd_o == 2'b00));

  // R7
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !enter_req) |=> ready_o);

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (ready_o && enter_req) |=> (!ready_o && !cke_o));
endmodule

bind sr_exit_seq sr_exit_seq_chk u_chk (
  .clk(clk), .rst(rst), .clk_running(clk_running), .enter_req(enter_req),
  .cke_o(cke_o), .cmd_o(cmd_o), .ready_o(ready_o)
);

// File: tb/sr_exit_seq_test.sv
module sr_exit_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TRC_W = 8;
  localparam int NREF = 2048;
  localparam int WATCHDOG = 180000;

  logic clk = 1'b0;
  logic rst, exit_req, enter_req, clk_running, burst_en;
  logic [TRC_W-1:0] trc_cycles;
  logic cke_o, ready_o;
  logic [1:0] cmd_o;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  sr_exit_seq #(.TRC_W(TRC_W), .REF_COUNT(NREF)) uut (
    .clk(clk), .rst(rst), .exit_req(exit_req), .enter_req(enter_req),
    .clk_running(clk_running), .burst_en(burst_en), .trc_cycles(trc_cycles),
    .cke_o(cke_o), .cmd_o(cmd_o), .ready_o(ready_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary_and_end();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic chk_out(input string req, input logic ecke, input logic [1:0] ecmd,
                         input logic erdy);
    chk(cke_o === ecke,  req, int'(cke_o),  int'(ecke));
    chk(cmd_o === ecmd,  req, int'(cmd_o),  int'(ecmd));
    chk(ready_o === erdy, req, int'(ready_o), int'(erdy));
  endtask

  function automatic int eff_trc(input int t);
    return (t < 1) ? 1 : t;
  endfunction

  function automatic logic [1:0] exp_cmd(input int k, input int t, input int n);
    if (k < n * (t + 1) && (k % (t + 1)) == t) return 2'b01;
    return 2'b00;
  endfunction

  // One exit sequence starting in the holding state at a negative edge.
  task automatic run_trial(input int trc, input bit burst, input int delay, input bit clk_pre);
    int t, n, k_end, arefs;
    t = eff_trc(trc);
    n = burst ? NREF : 0;
    k_end = n * (t + 1) + t;
    arefs = 0;
    burst_en = burst;
    trc_cycles = TRC_W'(trc);
    clk_running = clk_pre;
    exit_req = 1'b1;
    @(negedge clk);
    exit_req = 1'b0;
    if (!clk_pre) begin
      // R3: request pending, clock not yet running
      for (int i = 0; i < delay; i++) begin
        chk_out("R3", 1'b0, 2'b00, 1'b0);
        enter_req = ($urandom % 3 == 0);
        @(negedge clk);
      end
      enter_req = 1'b0;
      chk_out("R3", 1'b0, 2'b00, 1'b0);
      clk_running = 1'b1;
      @(negedge clk);
    end
    // k = 0 is the first cycle with cke high
    for (int k = 0; k <= k_end; k++) begin
      logic [1:0] ec;
      ec = exp_cmd(k, t, n);
      if (cmd_o === 2'b01) arefs++;
      if (k < t) chk_out("R4", 1'b1, ec, 1'b0);
      else if (k < k_end) chk_out(burst ? "R5" : "R6", 1'b1, ec, 1'b0);
      else chk_out("R7", 1'b1, 2'b00, 1'b1);
      if (trc == 0 && k == 1 && burst) chk(cmd_o === 2'b01, "R10", int'(cmd_o), 1);
      // R9: requests in mid-sequence must be ignored
      if (k < k_end - 1) begin
        enter_req = ($urandom % 5 == 0);
        exit_req  = ($urandom % 5 == 0);
      end else begin
        enter_req = 1'b0;
        exit_req = 1'b0;
      end
      if (k < k_end) @(negedge clk);
    end
    chk(arefs == n, burst ? "R5" : "R6", arefs, n);
    // R7: ready holds and ignores exit_req
    for (int i = 0; i < 3; i++) begin
      exit_req = (i == 1);
      @(negedge clk);
      chk_out("R7", 1'b1, 2'b00, 1'b1);
    end
    exit_req = 1'b0;
    // R8: back to holding state
    enter_req = 1'b1;
    clk_running = $urandom % 2;
    @(negedge clk);
    enter_req = 1'b0;
    chk_out("R8", 1'b0, 2'b00, 1'b0);
    // R2: stays asleep without a fresh exit request
    for (int i = 0; i < 4; i++) begin
      clk_running = $urandom % 2;
      enter_req = $urandom % 2;
      burst_en = $urandom % 2;
      @(negedge clk);
      chk_out("R2", 1'b0, 2'b00, 1'b0);
    end
    enter_req = 1'b0;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd4711);
    rst = 1'b1;
    exit_req = 1'b0;
    enter_req = 1'b0;
    clk_running = 1'b0;
    burst_en = 1'b0;
    trc_cycles = '0;
    repeat (3) @(negedge clk);
    chk_out("R1", 1'b0, 2'b00, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk_out("R1", 1'b0, 2'b00, 1'b0);
    // R2: clock running but no request
    clk_running = 1'b1;
    enter_req = 1'b1;
    repeat (3) @(negedge clk);
    enter_req = 1'b0;
    chk_out("R2", 1'b0, 2'b00, 1'b0);
    // directed corners
    run_trial(0, 1'b0, 0, 1'b1);   // R10
    run_trial(0, 1'b1, 3, 1'b0);   // R10 with burst
    run_trial(3, 1'b0, 6, 1'b0);
    run_trial(2, 1'b1, 0, 1'b1);
    // random trials
    for (int i = 0; i < 10; i++) begin
      run_trial(int'($urandom % 8), ($urandom % 6 == 0), int'($urandom % 7),
                bit'($urandom % 2));
    end
    summary_and_end();
  end
endmodule